// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block converts head-step requests arriving on a disk-drive interface into the four-phase drive pattern of a two-winding stepper motor. Its state is a pair of phase flip-flops. Each accepted step pulse moves the motor one phase, either forward or backward. The level of the direction line sets which way it moves.

A step pulse is accepted only while the drive is selected and no write is in progress. Acceptance happens at the pulse's rising edge. Every interface input first passes through a synchronizer on the system clock. The direction line and the current phase bits are combined with exclusive-OR logic to choose which flip-flop toggles. As a result, exactly one winding current reverses per step, and the phase sequence forms a two-bit Gray code. Four active-high coil-driver enables are decoded from the two phase bits.

Top module: `stp_sequencer`

## Requirements
- R1: While `por_n` is low, and after its release with no accepted step, `phase_o` is 2'b00 (phase 0) and `coil_o` is 4'b0101.
- R2: With `dir_i` low (toward higher tracks), accepted steps advance the phase 0→1→2→3→0. The encoding on `phase_o` = {A,B} is 00, 01, 11, 10 for phases 0, 1, 2, 3.
- R3: With `dir_i` high (toward track 00), accepted steps move the phase backwards: 0→3→2→1→0.
- R4: Each accepted step changes exactly one of the two phase bits. With no accepted step, `phase_o` holds its value.
- R5: A step pulse arriving while `sel_n_i` is high (drive not selected) leaves the phase unchanged.
- R6: A step pulse arriving while `wgate_n_i` is low (writing) leaves the phase unchanged.
- R7: A step is taken only on a rising edge of `step_i`. A pulse held high for any number of cycles produces exactly one phase change.
- R8: `coil_o` = {A, ~A, B, ~B}, with bit 3 = A, bit 2 = not A, bit 1 = B and bit 0 = not B.
- R9: An accepted rising edge of `step_i` appears on `phase_o` within SYNC_STAGES+2 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dir_i | input | 1 | Step direction: high toward track 00, low toward higher tracks |
| step_i | input | 1 | Step pulse; the rising edge requests one step |
| sel_n_i | input | 1 | Unit select, active low |
| wgate_n_i | input | 1 | Write gate, active low; stepping is blocked while low |
| phase_o | output | 2 | Current phase bits {A,B} |
| coil_o | output | 4 | Coil enables {A, ~A, B, ~B} |

## Verification
A wrong phase state is visible on `phase_o` and `coil_o` at once, because both come straight from the two flip-flops. A toggle-select fault shows as a skipped or reversed phase, or as two bits changing together, on the first step that crosses the affected transition. A fault in the qualifying logic shows as a phase change after a pulse that should have been blocked, or as a second change during one long pulse. The bench compares the full encoding after every pulse, so any of these faults is reported within one step.

// File: rtl/stp_pkg.sv
package stp_pkg;

   // Gray-coded phase bits {A,B}
   typedef logic [1:0] phase_t;

   localparam phase_t PH_ZERO = 2'b00;

   // Returns 1 when bit A must toggle for the next step.
   // Forward: A toggles when A!=B; reverse: A toggles when A==B.
   function automatic logic toggle_a(input phase_t ph, input logic reverse);
      return (ph[1] ^ ph[0]) ^ reverse;
   endfunction

endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("stp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               chain[s] <= '0;
            end else if (s == 0) begin
               chain[s] <= d_i;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/stp_gate.sv
module stp_gate #(
   parameter bit SEL_ACTIVE_LOW = 1'b1,
   parameter bit WG_ACTIVE_LOW  = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic step_s,
   input  logic sel_s,
   input  logic wg_s,
   output logic adv_o
);

   logic selected;
   logic writing;
   logic step_q;

   generate
      if (SEL_ACTIVE_LOW) begin : g_sel_lo
         assign selected = ~sel_s;
      end else begin : g_sel_hi
         assign selected = sel_s;
      end
      if (WG_ACTIVE_LOW) begin : g_wg_lo
         assign writing = ~wg_s;
      end else begin : g_wg_hi
         assign writing = wg_s;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) step_q <= 1'b0;
      else        step_q <= step_s;
   end

   assign adv_o = step_s & ~step_q & selected & ~writing;

   // R7: an advance pulse never lasts two cycles
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
      adv_o |=> !adv_o);

   // R5 and R6: no advance while deselected or writing
   a_r5_r6_qualified: assert property (@(posedge clk) disable iff (!por_n)
      (!selected || writing) |-> !adv_o);

endmodule

// File: rtl/stp_phase.sv
module stp_phase
   import stp_pkg::*;
#(
   parameter bit HOME_LEVEL = 1'b1
) (
   input  logic   clk,
   input  logic   por_n,
   input  logic   adv_i,
   input  logic   dir_s,
   output phase_t phase_o
);

   phase_t ph_q;
   logic   reverse;
   logic   flip_a;

   assign reverse = (dir_s == HOME_LEVEL);
   assign flip_a  = toggle_a(ph_q, reverse);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ph_q <= PH_ZERO;
      end else if (adv_i) begin
         ph_q <= flip_a ? {~ph_q[1], ph_q[0]} : {ph_q[1], ~ph_q[0]};
      end
   end

   assign phase_o = ph_q;

   // R1: phase 0 while reset is applied
   always @(posedge clk) begin
      if (!por_n) a_r1_reset_phase: assert (ph_q == PH_ZERO);
   end

   // R4: exactly one bit changes on an accepted step
   a_r4_one_bit: assert property (@(posedge clk) disable iff (!por_n)
      adv_i |=> $countones(ph_q ^ $past(ph_q)) == 1);

   // R4: state holds without a step
   a_r4_hold: assert property (@(posedge clk) disable iff (!por_n)
      !adv_i |=> $stable(ph_q));

   // R2: forward step from phase 0 goes to phase 1
   a_r2_forward: assert property (@(posedge clk) disable iff (!por_n)
      (adv_i && !reverse && ph_q == 2'b00) |=> ph_q == 2'b01);

   // R3: reverse step from phase 0 goes to phase 3
   a_r3_reverse: assert property (@(posedge clk) disable iff (!por_n)
      (adv_i && reverse && ph_q == 2'b00) |=> ph_q == 2'b10);

endmodule

// File: rtl/stp_coil_dec.sv
module stp_coil_dec
   import stp_pkg::*;
#(
   parameter bit ENABLE_ACTIVE_LOW = 1'b0
) (
   input  phase_t     phase_i,
   output logic [3:0] coil_o
);

   logic [3:0] raw;

   assign raw = {phase_i[1], ~phase_i[1], phase_i[0], ~phase_i[0]};

   generate
      if (ENABLE_ACTIVE_LOW) begin : g_inv
         assign coil_o = ~raw;
      end else begin : g_pass
         assign coil_o = raw;
      end
   endgenerate

endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
   import stp_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit HOME_LEVEL     = 1'b1,
   parameter bit SEL_ACTIVE_LOW = 1'b1,
   parameter bit WG_ACTIVE_LOW  = 1'b1
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       dir_i,
   input  logic       step_i,
   input  logic       sel_n_i,
   input  logic       wgate_n_i,
   output logic [1:0] phase_o,
   output logic [3:0] coil_o
);

   localparam int NUM_IN = 4;

   logic [NUM_IN-1:0] raw_in;
   logic [NUM_IN-1:0] sync_in;
   logic              adv;
   phase_t            phase;

   assign raw_in = {dir_i, step_i, sel_n_i, wgate_n_i};

   stp_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   stp_gate #(.SEL_ACTIVE_LOW(SEL_ACTIVE_LOW), .WG_ACTIVE_LOW(WG_ACTIVE_LOW)) u_gate (
      .clk    (clk),
      .por_n  (por_n),
      .step_s (sync_in[2]),
      .sel_s  (sync_in[1]),
      .wg_s   (sync_in[0]),
      .adv_o  (adv)
   );

   stp_phase #(.HOME_LEVEL(HOME_LEVEL)) u_phase (
      .clk     (clk),
      .por_n   (por_n),
      .adv_i   (adv),
      .dir_s   (sync_in[3]),
      .phase_o (phase)
   );

   stp_coil_dec #(.ENABLE_ACTIVE_LOW(1'b0)) u_dec (
      .phase_i (phase),
      .coil_o  (coil_o)
   );

   assign phase_o = phase;

   // R8: paired enables of each winding are never both on
   a_r8_coil_pairs: assert property (@(posedge clk) disable iff (!por_n)
      (coil_o[3] ^ coil_o[2]) && (coil_o[1] ^ coil_o[0]));

endmodule

// File: tb/stp_sequencer_bench.sv
module stp_sequencer_bench;

   localparam time CLK_PERIOD = 10ns;
   localparam int  SYNC       = 2;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       dir_i = 1'b0;
   logic       step_i = 1'b0;
   logic       sel_n_i = 1'b0;
   logic       wgate_n_i = 1'b1;
   logic [1:0] phase_o;
   logic [3:0] coil_o;

   int checks = 0;
   int errors = 0;
   int exp_idx = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stp_sequencer #(.SYNC_STAGES(SYNC)) u_stp_sequencer (
      .clk(clk), .por_n(por_n), .dir_i(dir_i), .step_i(step_i),
      .sel_n_i(sel_n_i), .wgate_n_i(wgate_n_i),
      .phase_o(phase_o), .coil_o(coil_o)
   );

   function automatic logic [1:0] gray(input int i);
      logic [1:0] b;
      b = 2'(i);
      return b ^ (b >> 1);
   endfunction

   task automatic check(input string req);
      logic [1:0] ep;
      logic [3:0] ec;
      ep = gray(exp_idx);
      ec = {ep[1], ~ep[1], ep[0], ~ep[0]};
      checks++;
      if (phase_o !== ep || coil_o !== ec) begin
         errors++;
         $display("FAIL %s: phase=%b coil=%b expected phase=%b coil=%b",
                  req, phase_o, coil_o, ep, ec);
      end
   endtask

   // one pulse of given high length, then settle beyond the latency
   task automatic pulse(input int high_cycles);
      @(negedge clk) step_i = 1'b1;
      repeat (high_cycles) @(negedge clk);
      step_i = 1'b0;
      repeat (SYNC + 4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 during reset");
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 after release");
   endtask

   task automatic t_forward();
      dir_i = 1'b0;
      for (int k = 0; k < 5; k++) begin
         pulse(2);
         exp_idx = (exp_idx + 1) % 4;
         check("R2 forward step, R4, R8");
      end
   endtask

   task automatic t_reverse();
      dir_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
         pulse(2);
         exp_idx = (exp_idx + 3) % 4;
         check("R3 reverse step, R4, R8");
      end
   endtask

   task automatic t_deselected();
      sel_n_i = 1'b1;
      pulse(2);
      check("R5 deselected step ignored");
      pulse(5);
      check("R5 deselected long step ignored");
      sel_n_i = 1'b0;
      repeat (4) @(negedge clk);
      check("R5 no late step after reselect");
   endtask

   task automatic t_writing();
      wgate_n_i = 1'b0;
      pulse(2);
      check("R6 step during write ignored");
      wgate_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 no late step after write ends");
   endtask

   task automatic t_long_pulse();
      dir_i = 1'b0;
      pulse(40);
      exp_idx = (exp_idx + 1) % 4;
      check("R7 long pulse gives one step");
   endtask

   task automatic t_latency();
      dir_i = 1'b0;
      @(negedge clk) step_i = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      exp_idx = (exp_idx + 1) % 4;
      check("R9 step visible within latency");
      step_i = 1'b0;
      repeat (SYNC + 4) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_forward();
      t_reverse();
      t_deselected();
      t_writing();
      t_long_pulse();
      t_latency();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule